// File: doc/BRIEF.md
# Two-Dimensional Word Address Sequencer

This block produces the word addresses for one channel of a memory-to-peripheral transfer engine. Software-side logic loads a start word address, a line length, a line stride and a line count, then pulses a start command. The sequencer offers one 32-bit-word address per beat on a valid/ready request port. The data mover behind it accepts each beat, and the address advances only on accepted beats.

A non-zero line length selects the rectangular mode. The sequencer walks `cfg_line_cnt + 1` lines of `cfg_line_len` words each. Consecutive line starts are `cfg_stride` words apart, and the gap words between the end of a line and the next line start are never requested. After the final word it raises a one-cycle done pulse and goes idle.

A line length of zero selects the circular double-buffer mode. The address climbs from the start through a region of `cfg_stride * (cfg_line_cnt + 1)` words and then wraps back to the start. A half event fires when the beat at the end of the first half is accepted, and a full event fires when the beat at the end of the region is accepted. This mode runs until it is stopped. The region size is assumed to be even and at least 2.

A burst flag groups beats in fours, marked by first/last tags. A group also closes at the end of a line (rectangular mode) or at the end of a half (circular mode). A pause input holds the position. Stop returns the block to idle at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy`, `req_valid`, `evt_done`, `evt_half` and `evt_full` are all 0.
- R2: In rectangular mode, the k-th accepted beat of line l carries address start + l*stride + k, for k below the line length. The address changes only after a beat where `req_valid` and `req_ready` are both 1.
- R3: A line count of 0 produces exactly one line of `cfg_line_len` beats.
- R4: In rectangular mode, `evt_done` is 1 for exactly one cycle, beginning the cycle after the last beat is accepted. `busy` is 0 in that same cycle, and `evt_done` is 0 at all other times.
- R5: With `cfg_line_len` = 0, beat n carries start + (n mod S), where S = stride*(count+1). The mode continues until `cmd_stop`.
- R6: In circular mode, `evt_half` pulses for one cycle after the beat at offset S/2-1 is accepted, and `evt_full` pulses for one cycle after the beat at offset S-1 is accepted. `evt_done` never fires in this mode.
- R7: With `cfg_burst` = 0, every beat has `req_first` = `req_last` = 1. With `cfg_burst` = 1, `req_first` marks the opening beat of each group. `req_last` marks the fourth beat of a group, the last beat of a line (rectangular mode), or the beat at offset S/2-1 or S-1 (circular mode), and the next beat then opens a new group.
- R8: While `cmd_pause` is 1, `req_valid` is 0 whenever no burst group is open. In burst mode, an open group runs to its last beat first. When pause is released, the sequence resumes from the held address with nothing skipped.
- R9: A cycle with `cmd_stop` = 1 leaves the block idle on the next cycle, with `busy` = 0 and `req_valid` = 0. No event follows, even when the final beat was offered in that same cycle.
- R10: `cmd_start` is ignored while `busy` is 1. All configuration inputs are sampled only on the accepted start.
- R11: While `req_valid` is 1 and `req_ready` is 0, `req_addr` holds its value on the next cycle unless `req_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_addr | input | ADDR_W (30) | First word address |
| cfg_line_len | input | LEN_W (16) | Words per line; 0 selects circular mode |
| cfg_stride | input | LEN_W (16) | Word distance between line starts |
| cfg_line_cnt | input | CNT_W (16) | Number of lines minus one |
| cfg_burst | input | 1 | 1 groups beats in fours |
| cmd_start | input | 1 | Start pulse, honoured when idle |
| cmd_stop | input | 1 | Abort to idle without an event |
| cmd_pause | input | 1 | Level: hold position while high |
| req_valid | output | 1 | Address beat offered |
| req_ready | input | 1 | Beat accepted by the data mover |
| req_addr | output | ADDR_W (30) | Word address of the beat |
| req_first | output | 1 | Beat opens a group |
| req_last | output | 1 | Beat closes a group |
| evt_done | output | 1 | Rectangular transfer finished (pulse) |
| evt_half | output | 1 | First half of loop region consumed (pulse) |
| evt_full | output | 1 | Second half of loop region consumed (pulse) |
| busy | output | 1 | Sequencer active |

## Verification
Several properties are checked on every cycle by assertions:
- the address is held while a beat stalls;
- the word and line counters, and the loop offset, stay within their configured bounds;
- single-beat mode never opens a group;
- the three events are mutually exclusive, and done coincides with idle;
- stop empties the block on the next cycle, and circular mode persists until stop.

Other behaviours can only be shown by the bench's scenarios, which compare every accepted address against sums computed independently:
- the exact address order across lines, wrap points and stalls;
- where the burst tags close, including at a half boundary;
- that a pause lets an open group finish and then resumes with nothing skipped;
- that a start issued mid-transfer has no effect;
- that a stop on the final beat swallows the done pulse.

// File: rtl/dma2d_pkg.sv
// Shared types of the two-dimensional word address sequencer.
// Assumes: nothing beyond the types declared here.
package dma2d_pkg;

    // Run state of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECT = 2'd1,
        ST_LOOP = 2'd2
    } run_state_e;

    // Position flags describing the beat currently offered.
    typedef struct packed {
        logic line_end;   // last word of the current line
        logic xfer_end;   // last word of the last line
        logic half_end;   // loop offset at end of first half
        logic full_end;   // loop offset at end of region
    } pos_flags_t;

endpackage

// File: rtl/dma2d_ctrl.sv
// Run-state control: accepts start/stop, gates the beat offer under pause,
// and registers the completion and loop events.
// Assumes: fire is req_valid & req_ready from the top; grp_open comes from the
// burst tagger and is 1 only while a burst group has started but not closed.
module dma2d_ctrl
    import dma2d_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_stop,
    input  logic       cmd_pause,
    input  logic       loop_sel,
    input  logic       fire,
    input  pos_flags_t flags,
    input  logic       grp_open,
    output run_state_e state_q,
    output logic       load,
    output logic       req_valid,
    output logic       evt_done,
    output logic       evt_half,
    output logic       evt_full
);

    // Start is taken only from idle, and never in a stop cycle.
    assign load = (state_q == ST_IDLE) && cmd_start && !cmd_stop;

    // Offer a beat while running unless a pause lands on a group boundary.
    assign req_valid = (state_q != ST_IDLE) && !(cmd_pause && !grp_open);

    // State register: stop wins, start leaves idle, the final beat returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (cmd_stop) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (cmd_start) state_q <= loop_sel ? ST_LOOP : ST_RECT;
                ST_RECT: if (fire && flags.xfer_end) state_q <= ST_IDLE;
                ST_LOOP: state_q <= ST_LOOP;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Event pulses, one cycle after the triggering beat; stop suppresses them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_done <= 1'b0;
            evt_half <= 1'b0;
            evt_full <= 1'b0;
        end else begin
            evt_done <= !cmd_stop && fire && (state_q == ST_RECT) && flags.xfer_end;
            evt_half <= !cmd_stop && fire && (state_q == ST_LOOP) && flags.half_end;
            evt_full <= !cmd_stop && fire && (state_q == ST_LOOP) && flags.full_end;
        end
    end

    // R9: a stop cycle always leaves the block idle.
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (state_q == ST_IDLE));

    // R4: the done pulse coincides with idle.
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> (state_q == ST_IDLE));

    // R6: at most one event per cycle.
    a_r6_evt_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_done, evt_half, evt_full}));

    // R6: loop events only while the loop is still running.
    a_r6_loop_only: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_half || evt_full) |-> (state_q == ST_LOOP));

    // R5: circular mode persists until a stop arrives.
    a_r5_loop_persist: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOOP) && !cmd_stop) |=> (state_q == ST_LOOP));

endmodule

// File: rtl/dma2d_walk.sv
// Address walker: latches the geometry on load and steps the line/word
// counters (rectangular mode) or the wrapping offset (circular mode) on
// every accepted beat.
// Assumes: load and fire are never high together; circular region is even, >= 2.
module dma2d_walk
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              fire,
    input  logic              active,
    input  logic              loop_mode,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [LEN_W-1:0]  cfg_line_len,
    input  logic [LEN_W-1:0]  cfg_stride,
    input  logic [CNT_W-1:0]  cfg_line_cnt,
    output logic [ADDR_W-1:0] addr,
    output pos_flags_t        flags
);

    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [LEN_W-1:0]  ONE_L = LEN_W'(1);
    localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] line_base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  stride_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] region_last_q;
    logic [ADDR_W-1:0] half_last_q;
    logic [LEN_W-1:0]  word_idx;
    logic [CNT_W-1:0]  line_idx;
    logic [ADDR_W-1:0] loop_off;
    logic [ADDR_W-1:0] region_words;

    // Loop region size from the configuration presented at start.
    assign region_words = ADDR_W'(cfg_stride) * (ADDR_W'(cfg_line_cnt) + ONE_A);

    // Geometry latch: configuration is captured only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q        <= '0;
            len_q         <= '0;
            stride_q      <= '0;
            cnt_q         <= '0;
            region_last_q <= '0;
            half_last_q   <= '0;
        end else if (load) begin
            base_q        <= cfg_start_addr;
            len_q         <= cfg_line_len;
            stride_q      <= cfg_stride;
            cnt_q         <= cfg_line_cnt;
            region_last_q <= region_words - ONE_A;
            half_last_q   <= (region_words >> 1) - ONE_A;
        end
    end

    // Position counters: reset on load, stepped on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base_q <= '0;
            word_idx    <= '0;
            line_idx    <= '0;
            loop_off    <= '0;
        end else if (load) begin
            line_base_q <= cfg_start_addr;
            word_idx    <= '0;
            line_idx    <= '0;
            loop_off    <= '0;
        end else if (fire) begin
            if (loop_mode) begin
                loop_off <= flags.full_end ? '0 : loop_off + ONE_A;
            end else if (flags.line_end) begin
                word_idx    <= '0;
                line_idx    <= line_idx + ONE_C;
                line_base_q <= line_base_q + ADDR_W'(stride_q);
            end else begin
                word_idx <= word_idx + ONE_L;
            end
        end
    end

    // Beat address and position flags for the beat on offer.
    always_comb begin
        flags.line_end = (word_idx == len_q - ONE_L);
        flags.xfer_end = flags.line_end && (line_idx == cnt_q);
        flags.half_end = (loop_off == half_last_q);
        flags.full_end = (loop_off == region_last_q);
        addr = loop_mode ? (base_q + loop_off) : (line_base_q + ADDR_W'(word_idx));
    end

    // R2: the word counter stays inside the line.
    a_r2_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !loop_mode) |-> (word_idx < len_q));

    // R3: the line counter never passes the configured count.
    a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !loop_mode) |-> (line_idx <= cnt_q));

    // R5: the loop offset stays inside the region.
    a_r5_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (active && loop_mode) |-> (loop_off <= region_last_q));

endmodule

// File: rtl/dma2d_burst.sv
// Burst tagger: tracks the position inside a group of BURST_BEATS beats and
// produces first/last tags; a segment end closes the group early.
// Assumes: load and fire are never high together.
module dma2d_burst #(
    parameter int BURST_BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cfg_burst,
    input  logic fire,
    input  logic seg_end,
    output logic beat_first,
    output logic beat_last,
    output logic grp_open
);

    localparam int                POS_W   = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(BURST_BEATS - 1);

    logic             burst_q;
    logic [POS_W-1:0] bpos;

    // Tags for the beat on offer.
    always_comb begin
        beat_first = !burst_q || (bpos == '0);
        beat_last  = !burst_q || (bpos == POS_MAX) || seg_end;
        grp_open   = burst_q && (bpos != '0);
    end

    // Group position: cleared on load, restarted after a closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            bpos    <= '0;
        end else if (load) begin
            burst_q <= cfg_burst;
            bpos    <= '0;
        end else if (fire) begin
            bpos <= beat_last ? '0 : bpos + POS_W'(1);
        end
    end

    // R7: single-beat mode never leaves a group open.
    a_r7_single_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_q |-> (bpos == '0));

    // R7: a closing beat is followed by an opening beat.
    a_r7_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && beat_last && !load) |=> beat_first);

endmodule

// File: rtl/dma2d_addr_gen.sv
// Top of the two-dimensional word address sequencer: joins the run control,
// the address walker and the burst tagger, and presents the request port.
// Assumes: a data mover consumes beats through req_valid/req_ready.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W      = 30,
    parameter int LEN_W       = 16,
    parameter int CNT_W       = 16,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [LEN_W-1:0]  cfg_line_len,
    input  logic [LEN_W-1:0]  cfg_stride,
    input  logic [CNT_W-1:0]  cfg_line_cnt,
    input  logic              cfg_burst,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_pause,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_first,
    output logic              req_last,
    output logic              evt_done,
    output logic              evt_half,
    output logic              evt_full,
    output logic              busy
);

    run_state_e state_q;
    pos_flags_t flags;
    logic       load;
    logic       fire;
    logic       grp_open;
    logic       loop_mode;
    logic       seg_end;

    // Handshake and mode decode.
    assign fire      = req_valid && req_ready;
    assign loop_mode = (state_q == ST_LOOP);
    assign busy      = (state_q != ST_IDLE);
    assign seg_end   = loop_mode ? (flags.half_end || flags.full_end) : flags.line_end;

    dma2d_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_pause (cmd_pause),
        .loop_sel  (cfg_line_len == '0),
        .fire      (fire),
        .flags     (flags),
        .grp_open  (grp_open),
        .state_q   (state_q),
        .load      (load),
        .req_valid (req_valid),
        .evt_done  (evt_done),
        .evt_half  (evt_half),
        .evt_full  (evt_full)
    );

    dma2d_walk #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_walk (
        .clk            (clk),
        .rst_n          (rst_n),
        .load           (load),
        .fire           (fire),
        .active         (busy),
        .loop_mode      (loop_mode),
        .cfg_start_addr (cfg_start_addr),
        .cfg_line_len   (cfg_line_len),
        .cfg_stride     (cfg_stride),
        .cfg_line_cnt   (cfg_line_cnt),
        .addr           (req_addr),
        .flags          (flags)
    );

    dma2d_burst #(
        .BURST_BEATS (BURST_BEATS)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cfg_burst  (cfg_burst),
        .fire       (fire),
        .seg_end    (seg_end),
        .beat_first (req_first),
        .beat_last  (req_last),
        .grp_open   (grp_open)
    );

    // R11: a stalled beat keeps its address.
    a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !cmd_stop) |=> (!req_valid || $stable(req_addr)));

    // R1: nothing is offered while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

endmodule

// File: tb/dma2d_addr_gen_tb.sv
`timescale 1ns/1ps
// Directed bench for the two-dimensional word address sequencer.
module dma2d_addr_gen_tb;

    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_start_addr = '0;
    logic [15:0]   cfg_line_len = '0;
    logic [15:0]   cfg_stride = '0;
    logic [15:0]   cfg_line_cnt = '0;
    logic          cfg_burst = 1'b0;
    logic          cmd_start = 1'b0;
    logic          cmd_stop = 1'b0;
    logic          cmd_pause = 1'b0;
    logic          req_ready = 1'b0;
    logic          req_valid, req_first, req_last;
    logic [AW-1:0] req_addr;
    logic          evt_done, evt_half, evt_full, busy;

    int n_checks = 0;
    int n_errors = 0;
    int cyc_total = 0;

    // Sampled observations of one step.
    logic ob_done, ob_half, ob_full, ob_busy, ob_valid, ob_first, ob_last;
    logic [AW-1:0] ob_addr;

    always #4 clk = ~clk;

    dma2d_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_addr(cfg_start_addr), .cfg_line_len(cfg_line_len),
        .cfg_stride(cfg_stride), .cfg_line_cnt(cfg_line_cnt), .cfg_burst(cfg_burst),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_pause(cmd_pause),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_first(req_first), .req_last(req_last),
        .evt_done(evt_done), .evt_half(evt_half), .evt_full(evt_full), .busy(busy)
    );

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 100000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc_total);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_errors = n_errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: observe registered outputs, drive inputs, then see the offer.
    task automatic step(input logic rdy, input logic pse, input logic stp,
                        input logic sta, output logic acc);
        @(negedge clk);
        ob_done = evt_done; ob_half = evt_half; ob_full = evt_full; ob_busy = busy;
        req_ready = rdy; cmd_pause = pse; cmd_stop = stp; cmd_start = sta;
        #1;
        ob_valid = req_valid; ob_addr = req_addr; ob_first = req_first; ob_last = req_last;
        acc = req_valid && req_ready && !stp;
    endtask

    task automatic do_start(input int sa, input int len, input int str, input int cnt,
                            input logic bm);
        logic acc;
        cfg_start_addr = AW'(sa); cfg_line_len = 16'(len); cfg_stride = 16'(str);
        cfg_line_cnt = 16'(cnt); cfg_burst = bm;
        step(1'b0, 1'b0, 1'b0, 1'b1, acc);
    endtask

    // R1: idle state after reset.
    task automatic test_reset();
        logic acc;
        step(1'b1, 1'b0, 1'b0, 1'b0, acc);
        chk(!ob_busy, "R1", "busy", ob_busy, 0);
        chk(!ob_valid, "R1", "valid", ob_valid, 0);
        chk(!(ob_done || ob_half || ob_full), "R1", "events",
            {ob_done, ob_half, ob_full}, 0);
    endtask

    // Rectangular transfer with optional stalls, pause and mid-run restart.
    task automatic run_rect(input int sa, input int len, input int str, input int cnt,
                            input logic bm, input int rmod, input int pause_at,
                            input int restart_at, input string tag);
        logic acc, rdy, pse, sta;
        int total, k, l, w, bc, cyc, pz_left;
        logic e_first, e_last;
        longint e_addr;
        total = len * (cnt + 1);
        k = 0; l = 0; w = 0; bc = 0; cyc = 0; pz_left = 5;
        do_start(sa, len, str, cnt, bm);
        while (k < total && cyc < 4000) begin
            cyc++;
            pse = (pause_at >= 0) && (k >= pause_at) && (pz_left > 0);
            rdy = pse ? 1'b1 : ((rmod == 0) ? 1'b1 : ((cyc % rmod) != 0));
            sta = (restart_at >= 0) && (k == restart_at) && (cyc < 4000);
            if (sta) begin
                restart_at = -1;
                cfg_start_addr = AW'(sa + 777); cfg_line_len = 16'(len + 3);
                cfg_line_cnt = 16'(cnt + 2); cfg_burst = !bm;
            end
            step(rdy, pse, 1'b0, sta, acc);
            if (pse) pz_left--;
            chk(!ob_done, "R4", "early done", ob_done, 0);
            if (pse)
                chk(ob_valid == (bm && bc != 0), "R8", "valid under pause",
                    ob_valid, (bm && bc != 0));
            if (acc) begin
                e_addr  = sa + l * str + w;
                e_first = !bm || (bc == 0);
                e_last  = !bm || (bc == 3) || (w == len - 1);
                chk(ob_addr == AW'(e_addr), tag, "address", ob_addr, e_addr);
                chk(ob_first == e_first, "R7", "first tag", ob_first, e_first);
                chk(ob_last == e_last, "R7", "last tag", ob_last, e_last);
                bc = e_last ? 0 : bc + 1;
                w++;
                if (w == len) begin w = 0; l++; end
                k++;
            end
        end
        chk(k == total, tag, "beats accepted", k, total);
        step(1'b0, 1'b0, 1'b0, 1'b0, acc);
        chk(ob_done, "R4", "done pulse", ob_done, 1);
        chk(!ob_busy, "R4", "busy at done", ob_busy, 0);
        step(1'b0, 1'b0, 1'b0, 1'b0, acc);
        chk(!ob_done, "R4", "done width", ob_done, 0);
        chk(!ob_valid, "R10", "no extra beats", ob_valid, 0);
    endtask

    // Circular transfer for nbeats beats, then stop.
    task automatic run_loop(input int sa, input int str, input int cnt, input logic bm,
                            input int rmod, input int nbeats);
        logic acc, rdy, e_first, e_last, p_half, p_full;
        int size, half, k, bc, cyc, off;
        size = str * (cnt + 1); half = size / 2;
        k = 0; bc = 0; cyc = 0; p_half = 0; p_full = 0;
        do_start(sa, 0, str, cnt, bm);
        while (k < nbeats && cyc < 4000) begin
            cyc++;
            rdy = (rmod == 0) ? 1'b1 : ((cyc % rmod) != 0);
            step(rdy, 1'b0, 1'b0, 1'b0, acc);
            chk(ob_half == p_half, "R6", "half event", ob_half, p_half);
            chk(ob_full == p_full, "R6", "full event", ob_full, p_full);
            chk(!ob_done, "R6", "no done in loop", ob_done, 0);
            p_half = 0; p_full = 0;
            if (acc) begin
                off = k % size;
                e_first = !bm || (bc == 0);
                e_last  = !bm || (bc == 3) || (off == half - 1) || (off == size - 1);
                chk(ob_addr == AW'(sa + off), "R5", "loop address", ob_addr, sa + off);
                chk(ob_first == e_first, "R7", "loop first tag", ob_first, e_first);
                chk(ob_last == e_last, "R7", "loop last tag", ob_last, e_last);
                bc = e_last ? 0 : bc + 1;
                p_half = (off == half - 1);
                p_full = (off == size - 1);
                k++;
            end
        end
        chk(ob_busy, "R5", "still running", ob_busy, 1);
        step(1'b0, 1'b0, 1'b1, 1'b0, acc);
        chk(ob_half == p_half && ob_full == p_full, "R6", "last event",
            {ob_half, ob_full}, {p_half, p_full});
        step(1'b0, 1'b0, 1'b0, 1'b0, acc);
        chk(!ob_busy, "R9", "busy after stop", ob_busy, 0);
        chk(!ob_valid, "R9", "valid after stop", ob_valid, 0);
        chk(!(ob_half || ob_full || ob_done), "R9", "events after stop",
            {ob_done, ob_half, ob_full}, 0);
    endtask

    // R9: stop on the final beat suppresses done.
    task automatic test_stop_final();
        logic acc;
        do_start(50, 2, 2, 0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, acc);
        chk(acc && ob_addr == AW'(50), "R9", "first beat", ob_addr, 50);
        step(1'b1, 1'b0, 1'b1, 1'b0, acc);
        chk(ob_valid && ob_addr == AW'(51), "R9", "final beat offered", ob_addr, 51);
        step(1'b0, 1'b0, 1'b0, 1'b0, acc);
        chk(!ob_done, "R9", "done swallowed", ob_done, 0);
        chk(!ob_busy, "R9", "idle after stop", ob_busy, 0);
        step(1'b0, 1'b0, 1'b0, 1'b0, acc);
        chk(!ob_done && !ob_valid, "R9", "still quiet", {ob_done, ob_valid}, 0);
    endtask

    // R9: stop mid-transfer, then a fresh start runs from its own start address.
    task automatic test_stop_mid();
        logic acc;
        do_start(300, 4, 6, 3, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0, acc);
        step(1'b1, 1'b0, 1'b0, 1'b0, acc);
        step(1'b0, 1'b0, 1'b1, 1'b0, acc);
        step(1'b1, 1'b0, 1'b0, 1'b0, acc);
        chk(!ob_busy && !ob_valid, "R9", "mid stop idle", {ob_busy, ob_valid}, 0);
        chk(!ob_done, "R9", "mid stop no done", ob_done, 0);
        run_rect(900, 2, 3, 1, 1'b0, 0, -1, -1, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_rect(100, 3, 5, 2, 1'b0, 0, -1, -1, "R2");       // plain rectangle
        run_rect(2000, 6, 8, 1, 1'b1, 3, -1, -1, "R2");      // stalls + bursts
        run_rect(40, 5, 9, 0, 1'b0, 2, -1, -1, "R3");        // single line
        run_rect(500, 4, 4, 1, 1'b0, 0, 2, -1, "R8");        // pause, single beats
        run_rect(700, 8, 8, 0, 1'b1, 0, 1, -1, "R8");        // pause inside burst
        run_rect(1200, 3, 7, 2, 1'b0, 2, -1, 2, "R10");      // restart ignored
        run_loop(512, 4, 3, 1'b0, 0, 40);                    // circular, single
        run_loop(64, 6, 1, 1'b1, 3, 30);                     // circular, bursts, stalls
        test_stop_final();
        test_stop_mid();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule